// File: doc/BRIEF.md
# Dual-Space I2C Slave Addressing Front-End

This block is the bus side of an I2C slave that looks like one device on the wire but reaches two separate address spaces. One space is a data memory and the other is a bank of clock and control registers. The upper nibble of the slave byte chooses the space. A shared 16-bit word pointer is loaded from two address bytes, which are sent high byte first. The pointer then advances after each byte that is written or read. When the pointer passes the top of the selected space, it wraps to zero.

The block handles the following transfers:

- byte and multi-byte writes;
- current-address reads;
- random reads, made of an address-only write followed by a repeated start and a read;
- sequential reads that continue while the master acknowledges.

Both bus lines pass through a synchronizer into the system clock domain. The block pulls SDA low only through an open-drain enable. Each space has a simple synchronous port with the following timing:

- A write strobe is one clock wide.
- A read strobe is one clock wide, and the data comes back on the next clock.

Top module: `i2c_dual_space_slave`

## Requirements
- R1: A slave byte of 1010111x is acknowledged and targets the memory space. A slave byte of 1101111x is acknowledged and targets the register space. Bit 0 set means read and bit 0 clear means write.
- R2: A slave byte with any other type nibble, or with device bits [3:1] other than 111, gets no acknowledge. The slave then stays silent on every later byte, and changes no location, until the next start.
- R3: A write consists of the slave byte, the address high byte, the address low byte and one data byte. Each byte is acknowledged. The data lands at that address, masked to the width of the selected space, and no other space is strobed.
- R4: After each byte written, the word pointer advances by one, so further data bytes land at successive locations.
- R5: After reset the pointer is 0, so the first current-address read returns location 0.
- R6: A random read returns the byte at the address given in the dummy-write phase. A random read is an address-only write, then a repeated start, then a read slave byte of the same space.
- R7: If the read slave byte after a dummy write names the other space, it is not acknowledged and no data is driven.
- R8: In a sequential read, successive bytes are returned while the master acknowledges. After a master not-acknowledge, SDA stays released, so a further byte reads as FFh.
- R9: Incrementing past the top location of the selected space (2^MEM_AW-1 or 2^REG_AW-1) wraps the pointer to 0.
- R10: A stop returns the slave to idle but keeps the pointer, so a later current-address read continues from it.
- R11: A start at any point, even in the middle of a byte, restarts slave byte reception.
- R12: Outside reset, SDA is driven only during acknowledge slots and read data bits, and the drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low |
| mem_addr_o | output | MEM_AW | Memory space word address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_rdata_i | input | 8 | Memory read data, valid one clock after the read strobe |
| reg_addr_o | output | REG_AW | Register space address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 8 | Register read data, valid one clock after the read strobe |

## Verification
The assertions check the following on every cycle:

- The space strobes stay exclusive single-clock pulses.
- The idle state never drives SDA.
- SDA drive never changes while SCL is high.

The bench scenarios cover the rest:

- space decoding;
- the data that lands at or returns from each address;
- the check that a random read uses the same space in both phases;
- pointer wrap and the pointer surviving a stop;
- silence after a mismatched slave byte;
- restart in the middle of a byte.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK,
    ST_ALO, ST_ALO_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } phase_t;

  typedef enum logic {SP_MEM = 1'b0, SP_REG = 1'b1} space_t;

  localparam logic [3:0] TYPE_MEM = 4'b1010;
  localparam logic [3:0] TYPE_REG = 4'b1101;
  localparam logic [2:0] DEV_SEL  = 3'b111;

  function automatic logic slave_hit(input logic [7:0] b);
    return ((b[7:4] == TYPE_MEM) || (b[7:4] == TYPE_REG)) && (b[3:1] == DEV_SEL);
  endfunction

  // Bit 6 separates the two type codes (1010 vs 1101).
  function automatic space_t slave_space(input logic [7:0] b);
    return b[6] ? SP_REG : SP_MEM;
  endfunction

endpackage

// File: rtl/i2cds_line_sync.sv
module i2cds_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s      = scl_sh[STAGES-1];
  assign sda_s      = sda_sh[STAGES-1];
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2cds_word_ptr.sv
module i2cds_word_ptr
  import i2cds_pkg::*;
#(
  parameter int MEM_AW = 9,
  parameter int REG_AW = 6,
  localparam int AW_MAX = (MEM_AW > REG_AW) ? MEM_AW : REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [15:0]       load_val,
  input  logic              inc,
  input  space_t            space,
  output logic [AW_MAX-1:0] ptr_o
);
  localparam logic [AW_MAX-1:0] MEM_MASK = {AW_MAX{1'b1}} >> (AW_MAX - MEM_AW);
  localparam logic [AW_MAX-1:0] REG_MASK = {AW_MAX{1'b1}} >> (AW_MAX - REG_AW);

  logic [AW_MAX-1:0] mask, ptr_q;

  assign mask = (space == SP_REG) ? REG_MASK : MEM_MASK;

  generate
    if (AW_MAX < 16) begin : g_drop_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^load_val[15:AW_MAX];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= load_val[AW_MAX-1:0] & mask;
    else if (inc)  ptr_q <= (ptr_q + 1'b1) & mask;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_dual_space_slave.sv
module i2c_dual_space_slave
  import i2cds_pkg::*;
#(
  parameter int MEM_AW      = 9,
  parameter int REG_AW      = 6,
  parameter int SYNC_STAGES = 2,
  localparam int AW_MAX = (MEM_AW > REG_AW) ? MEM_AW : REG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [7:0]        reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

  i2cds_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(bus_start), .stop_o(bus_stop)
  );

  phase_t            phase_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q, hi_q, wdata_q;
  logic              oe_q, rd_q, armed_q, mack_q;
  space_t            space_q, re_sp_q, ptr_space;
  logic              we_q, re_q, rd_pend_q;
  logic [AW_MAX-1:0] addr_q, ptr;

  logic rx_phase, byte_end, dev_ok, dev_rd, rr_bad, dev_accept;
  logic do_load, do_write, do_fetch;
  space_t dev_sp;

  assign rx_phase   = (phase_q == ST_DEV) || (phase_q == ST_AHI) ||
                      (phase_q == ST_ALO) || (phase_q == ST_WR);
  assign byte_end   = scl_fall && rx_phase && (cnt_q == 4'd8);
  assign dev_ok     = slave_hit(sh_q);
  assign dev_sp     = slave_space(sh_q);
  assign dev_rd     = sh_q[0];
  assign rr_bad     = armed_q && dev_rd && (dev_sp != space_q);
  assign dev_accept = dev_ok && !rr_bad;
  assign do_load    = byte_end && (phase_q == ST_ALO);
  assign do_write   = byte_end && (phase_q == ST_WR);
  assign do_fetch   = (byte_end && (phase_q == ST_DEV) && dev_accept && dev_rd) ||
                      (scl_rise && (phase_q == ST_RD_ACK) && !sda_s);
  assign ptr_space  = (phase_q == ST_DEV) ? dev_sp : space_q;

  i2cds_word_ptr #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) i_ptr (
    .clk(clk), .rst(rst), .load(do_load), .load_val({hi_q, sh_q}),
    .inc(do_write || do_fetch), .space(ptr_space), .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      hi_q      <= '0;
      wdata_q   <= '0;
      oe_q      <= 1'b0;
      rd_q      <= 1'b0;
      armed_q   <= 1'b0;
      mack_q    <= 1'b0;
      space_q   <= SP_MEM;
      re_sp_q   <= SP_MEM;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      addr_q    <= '0;
    end else begin
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      rd_pend_q <= re_q;
      if (do_write) begin
        we_q    <= 1'b1;
        addr_q  <= ptr;
        wdata_q <= sh_q;
      end
      if (do_fetch) begin
        re_q    <= 1'b1;
        addr_q  <= ptr;
        re_sp_q <= ptr_space;
      end

      if (bus_stop) begin
        phase_q <= ST_IDLE;
        oe_q    <= 1'b0;
        armed_q <= 1'b0;
      end else if (bus_start) begin
        phase_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        if (rx_phase && scl_rise && (cnt_q < 4'd8)) begin
          sh_q  <= {sh_q[6:0], sda_s};
          cnt_q <= cnt_q + 1'b1;
        end
        if (byte_end) cnt_q <= '0;
        case (phase_q)
          ST_DEV: if (byte_end) begin
            armed_q <= 1'b0;
            if (dev_accept) begin
              oe_q    <= 1'b1;
              space_q <= dev_sp;
              rd_q    <= dev_rd;
              phase_q <= ST_DEV_ACK;
            end else begin
              phase_q <= ST_IDLE;
            end
          end
          ST_AHI: if (byte_end) begin
            hi_q    <= sh_q;
            oe_q    <= 1'b1;
            phase_q <= ST_AHI_ACK;
          end
          ST_ALO: if (byte_end) begin
            oe_q    <= 1'b1;
            armed_q <= 1'b1;
            phase_q <= ST_ALO_ACK;
          end
          ST_WR: if (byte_end) begin
            oe_q    <= 1'b1;
            armed_q <= 1'b0;
            phase_q <= ST_WR_ACK;
          end
          ST_DEV_ACK: if (scl_fall) begin
            if (rd_q) begin
              oe_q    <= ~tx_q[7];
              cnt_q   <= '0;
              phase_q <= ST_RD;
            end else begin
              oe_q    <= 1'b0;
              phase_q <= ST_AHI;
            end
          end
          ST_AHI_ACK: if (scl_fall) begin
            oe_q    <= 1'b0;
            phase_q <= ST_ALO;
          end
          ST_ALO_ACK, ST_WR_ACK: if (scl_fall) begin
            oe_q    <= 1'b0;
            phase_q <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_q    <= 1'b0;
              cnt_q   <= '0;
              phase_q <= ST_RD_ACK;
            end else begin
              tx_q  <= {tx_q[6:0], 1'b0};
              oe_q  <= ~tx_q[6];
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) mack_q <= ~sda_s;
            if (scl_fall) begin
              if (mack_q) begin
                oe_q    <= ~tx_q[7];
                cnt_q   <= '0;
                phase_q <= ST_RD;
              end else begin
                phase_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
      if (rd_pend_q) tx_q <= (re_sp_q == SP_REG) ? reg_rdata_i : mem_rdata_i;
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_addr_o  = addr_q[MEM_AW-1:0];
  assign reg_addr_o  = addr_q[REG_AW-1:0];
  assign mem_wdata_o = wdata_q;
  assign reg_wdata_o = wdata_q;
  assign mem_we_o    = we_q & (space_q == SP_MEM);
  assign reg_we_o    = we_q & (space_q == SP_REG);
  assign mem_re_o    = re_q & (re_sp_q == SP_MEM);
  assign reg_re_o    = re_q & (re_sp_q == SP_REG);
endmodule

// File: rtl/i2cds_checker.sv
module i2cds_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       mem_we,
  input logic       mem_re,
  input logic       reg_we,
  input logic       reg_re,
  input logic [3:0] phase
);
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re, reg_we, reg_re}));

  p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we || reg_we) |=> !(mem_we || reg_we));

  p_re_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_re || reg_re) |=> !(mem_re || reg_re));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (phase == 4'd0) |-> !sda_oe);

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_dual_space_slave i2cds_checker u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe_o),
  .mem_we(mem_we_o), .mem_re(mem_re_o), .reg_we(reg_we_o), .reg_re(reg_re_o),
  .phase(phase_q)
);

// File: tb/test_i2c_dual_space_slave.sv
module test_i2c_dual_space_slave;
  localparam int MEM_AW = 9;
  localparam int REG_AW = 6;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic scl_r = 1'b1, m_low = 1'b0;
  logic sda_oe, sda_line;
  logic [MEM_AW-1:0] mem_addr;
  logic [REG_AW-1:0] reg_addr;
  logic [7:0] mem_wdata, reg_wdata, mem_rd, reg_rd;
  logic mem_we, mem_re, reg_we, reg_re;

  assign sda_line = ~(m_low | sda_oe);

  i2c_dual_space_slave #(.MEM_AW(MEM_AW), .REG_AW(REG_AW)) i_i2c_dual_space_slave (
    .clk(clk), .rst(rst), .scl_i(scl_r), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_rdata_i(mem_rd),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_re_o(reg_re), .reg_rdata_i(reg_rd)
  );

  logic [7:0] mem_arr [0:(1<<MEM_AW)-1];
  logic [7:0] reg_arr [0:(1<<REG_AW)-1];

  always @(posedge clk) begin
    if (mem_we) mem_arr[mem_addr] <= mem_wdata;
    if (mem_re) mem_rd <= mem_arr[mem_addr];
    if (reg_we) reg_arr[reg_addr] <= reg_wdata;
    if (reg_re) reg_rd <= reg_arr[reg_addr];
  end

  function automatic logic [7:0] mem_init(input int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] reg_init(input int i);
    return 8'((i + 128) & 255);
  endfunction

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; tick(Q); scl_r = 1'b1; tick(2*Q); scl_r = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; tick(Q); scl_r = 1'b1; tick(Q); b = sda_line; tick(Q); scl_r = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl_r = 1'b1; tick(Q); m_low = 1'b1; tick(Q); scl_r = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl_r = 1'b1; tick(Q); m_low = 1'b0; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(~mack);
  endtask

  task automatic t_reset();
    chk("R12 reset sda released", {15'd0, sda_oe}, 16'd0);
    chk("R12 reset no strobes", {12'd0, mem_we, mem_re, reg_we, reg_re}, 16'd0);
  endtask

  task automatic t_current_after_reset();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hAF, a);
    chk("R1 memory read slave byte acked", {15'd0, a}, 16'd1);
    recv_byte(1'b0, d);
    chk("R5 first current read is location 0", {8'd0, d}, {8'd0, mem_init(0)});
    bus_stop();
  endtask

  task automatic t_stop_keeps_ptr();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hAF, a); recv_byte(1'b0, d); bus_stop();
    chk("R10 pointer kept across stop", {8'd0, d}, {8'd0, mem_init(1)});
  endtask

  task automatic t_byte_write();
    logic a0, a1, a2, a3;
    bus_start(); send_byte(8'hAE, a0); send_byte(8'h01, a1); send_byte(8'h23, a2);
    send_byte(8'hC5, a3); bus_stop();
    chk("R3 write bytes all acked", {12'd0, a0, a1, a2, a3}, 16'hF);
    chk("R3 data at 0x123", {8'd0, mem_arr[9'h123]}, 16'h00C5);
    chk("R3 register space untouched", {8'd0, reg_arr[6'h23]}, {8'd0, reg_init(6'h23)});
  endtask

  task automatic t_multi_write();
    logic a;
    bus_start(); send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h40, a);
    send_byte(8'h11, a); send_byte(8'h22, a); bus_stop();
    chk("R4 first byte at 0x40", {8'd0, mem_arr[9'h040]}, 16'h0011);
    chk("R4 second byte at 0x41", {8'd0, mem_arr[9'h041]}, 16'h0022);
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hDE, a);
    chk("R1 register write slave byte acked", {15'd0, a}, 16'd1);
    send_byte(8'h00, a); send_byte(8'h05, a); send_byte(8'h77, a); bus_stop();
    chk("R1 register space written", {8'd0, reg_arr[5]}, 16'h0077);
    chk("R1 memory not written at 5", {8'd0, mem_arr[5]}, {8'd0, mem_init(5)});
    bus_start(); send_byte(8'hAE, a); send_byte(8'h01, a); send_byte(8'h23, a);
    bus_start(); send_byte(8'hAF, a); recv_byte(1'b0, d); bus_stop();
    chk("R6 random read of memory 0x123", {8'd0, d}, 16'h00C5);
    bus_start(); send_byte(8'hDE, a); send_byte(8'h00, a); send_byte(8'h05, a);
    bus_start(); send_byte(8'hDF, a); recv_byte(1'b0, d); bus_stop();
    chk("R6 random read of register 5", {8'd0, d}, 16'h0077);
  endtask

  task automatic t_space_mismatch();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h10, a);
    bus_start(); send_byte(8'hDF, a);
    chk("R7 mismatched read slave byte not acked", {15'd0, a}, 16'd0);
    recv_byte(1'b0, d);
    chk("R7 no data driven", {8'd0, d}, 16'h00FF);
    bus_stop();
  endtask

  task automatic t_seq_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h10, a);
    bus_start(); send_byte(8'hAF, a);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, d);
      chk("R8 sequential byte", {8'd0, d}, {8'd0, mem_init(16 + i)});
    end
    recv_byte(1'b0, d);
    chk("R8 released after master nack", {8'd0, d}, 16'h00FF);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'hAE, a); send_byte(8'h01, a); send_byte(8'hFF, a);
    bus_start(); send_byte(8'hAF, a);
    recv_byte(1'b1, d);
    chk("R9 memory top byte", {8'd0, d}, {8'd0, mem_init(511)});
    recv_byte(1'b0, d);
    chk("R9 memory wraps to 0", {8'd0, d}, {8'd0, mem_init(0)});
    bus_stop();
    bus_start(); send_byte(8'hDE, a); send_byte(8'h00, a); send_byte(8'h3F, a);
    send_byte(8'hAA, a); send_byte(8'hBB, a); bus_stop();
    chk("R9 register top written", {8'd0, reg_arr[63]}, 16'h00AA);
    chk("R9 register wraps to 0", {8'd0, reg_arr[0]}, 16'h00BB);
  endtask

  task automatic t_no_match();
    logic a, b, c;
    bus_start(); send_byte(8'hA6, a); send_byte(8'h00, b); send_byte(8'h50, c);
    chk("R2 wrong device bits not acked", {13'd0, a, b, c}, 16'd0);
    send_byte(8'hEE, a); bus_stop();
    chk("R2 ignored data byte not acked", {15'd0, a}, 16'd0);
    chk("R2 memory 0x50 unchanged", {8'd0, mem_arr[9'h050]}, {8'd0, mem_init(16'h50)});
    bus_start(); send_byte(8'h9E, a); bus_stop();
    chk("R2 wrong type code not acked", {15'd0, a}, 16'd0);
  endtask

  task automatic t_restart_mid_byte();
    logic a;
    bus_start(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    bus_start(); send_byte(8'hAE, a);
    chk("R11 slave byte acked after mid-byte restart", {15'd0, a}, 16'd1);
    send_byte(8'h00, a); send_byte(8'h30, a); send_byte(8'h99, a); bus_stop();
    chk("R11 write after restart lands", {8'd0, mem_arr[9'h030]}, 16'h0099);
  endtask

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem_arr[i] = mem_init(i);
    for (int i = 0; i < (1 << REG_AW); i++) reg_arr[i] = reg_init(i);
    tick(5);
    rst = 1'b0;
    tick(5);
    t_reset();
    t_current_after_reset();
    t_stop_keeps_ptr();
    t_byte_write();
    t_multi_write();
    t_random_read();
    t_space_mismatch();
    t_seq_read();
    t_wrap();
    t_no_match();
    t_restart_mid_byte();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule